// File: doc/BRIEF.md
# Processor Clock Ratio Enable Generator

This block turns one fast clock domain into a family of four processor clock enables. Three clock-enable streams arrive as candidate sources. A control word picks one of them and sets a 6-bit divisor, and a second register holds a ratio mode bit. The selected stream is divided down to a base rate. A small phase state machine then spreads that base rate across four enable outputs. From fastest to slowest, these are the full, half, mid and slow ticks. Each output is a one-cycle pulse in the single clock domain, so no clock is ever gated.

The mode bit chooses between a 6:2:1 family and a 4:2:1 family. With the bit set, the mid tick is one base pulse in three and the slow tick is one in six. With the bit clear, they are one in two and one in four. The half tick is always one base pulse in two.

Software writes both registers through a simple write port. Each write lands in a pending copy. The pending copy becomes active only when a slow-tick period closes, so the four outputs always stay phase-aligned.

The phase state machine has six states, `PH0` to `PH5`, and it moves only on a base pulse:
- `PH0` to `PH1`, `PH1` to `PH2`, and `PH2` to `PH3` in both modes.
- `PH3` to `PH0` in 4:2:1 mode, or `PH3` to `PH4` in 6:2:1 mode.
- `PH4` to `PH5`, then `PH5` to `PH0` (6:2:1 mode only).

The base pulse taken in the last state (`PH3` or `PH5`) is the boundary. On that boundary the state returns to `PH0` and the pending configuration is loaded.

Top module: `cpu_ratio_gen`

## Requirements
- R1: Control word bits [5:4] pick the source. Codes 0 and 1 select `src_en[1]`, code 2 selects `src_en[2]`, and code 3 selects `src_en[0]`.
- R2: Control word bits [13:8] hold a divisor D. `tick_full` pulses once for every D cycles in which the selected source is high.
- R3: A divisor field of 0 divides by 1.
- R4: `tick_half` pulses on every second `tick_full`, including the one that carries `tick_slow`, and never in two consecutive cycles.
- R5: When the ratio bit is set, `tick_mid` pulses on every third `tick_full` and `tick_slow` on every sixth.
- R6: When the ratio bit is clear, `tick_mid` pulses on every second `tick_full` and `tick_slow` on every fourth.
- R7: Every `tick_half`, `tick_mid` and `tick_slow` pulse coincides with a `tick_full` pulse, and a `tick_slow` pulse coincides with all three other outputs.
- R8: A register write changes no output until the current slow period ends. The new source, divisor and mode apply from the next `tick_slow` pulse, which is itself the first pulse counted under them.
- R9: Synchronous reset (`rst` high) selects source code 0, divisor 1 and 4:2:1 mode. All outputs stay low while `rst` is high, and the first `tick_full` after reset also carries `tick_slow`.
- R10: A write takes place only when `wr_en` is high. `wr_addr` = 0 addresses the control word, and `wr_addr` = 1 addresses the ratio register, whose bit 0 is the mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| src_en | input | 3 | Three source clock-enable streams |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control word, 1 = ratio register |
| wr_data | input | 14 | Write data |
| tick_full | output | 1 | Base-rate enable (6x/4x) |
| tick_half | output | 1 | Half-rate enable (3x/2x) |
| tick_mid | output | 1 | 2x enable, base/3 or base/2 |
| tick_slow | output | 1 | 1x enable, base/6 or base/4 |

## Verification
The sources run at three different rates: every cycle, every second cycle and every third cycle. Because of this, the measured gap between base pulses shows which source the decode picked, and it also separates a divisor of 0 from larger divisors. Each source code is paired with both ratio modes, so the counts of half, mid and full pulses within one slow period separate 6:2:1 from 4:2:1. The largest divisor checks that the prediv counter wraps correctly. Directed runs cover the reset defaults, the deferral of a write until the slow boundary, and a write attempt with the strobe low, which must leave the base-pulse gap unchanged.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
    localparam int SRC_N    = 3;
    localparam int SRC_LSB  = 4;
    localparam int DIV_LSB  = 8;
    localparam int DIV_W    = 6;
    localparam int MODE_BIT = 0;
    localparam int REG_W    = DIV_LSB + DIV_W;

    typedef enum logic [2:0] {
        PH0 = 3'd0,
        PH1 = 3'd1,
        PH2 = 3'd2,
        PH3 = 3'd3,
        PH4 = 3'd4,
        PH5 = 3'd5
    } phase_t;

    typedef struct packed {
        logic [1:0]       src_code;
        logic [DIV_W-1:0] div;
        logic             mode6;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{src_code: 2'd0, div: DIV_W'(1), mode6: 1'b0};
endpackage

// File: rtl/cpr_cfg.sv
module cpr_cfg
    import cpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             apply,
    output cfg_t             act
);
    cfg_t pend;
    logic unused_bits;

    assign unused_bits = ^{wr_data[SRC_LSB-1:MODE_BIT+1], wr_data[DIV_LSB-1:SRC_LSB+2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= CFG_RESET;
            act  <= CFG_RESET;
        end else begin
            if (wr_en) begin
                if (!wr_addr) begin
                    pend.src_code <= wr_data[SRC_LSB +: 2];
                    pend.div      <= wr_data[DIV_LSB +: DIV_W];
                end else begin
                    pend.mode6    <= wr_data[MODE_BIT];
                end
            end
            if (apply) begin
                act <= pend;
            end
        end
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(act)); // R8
endmodule

// File: rtl/cpr_prediv.sv
module cpr_prediv
    import cpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] src_en,
    input  logic [1:0]       src_code,
    input  logic [DIV_W-1:0] div,
    output logic             base_tick
);
    logic             sel;
    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] cnt;

    always_comb begin
        unique case (src_code)
            2'd0, 2'd1: sel = src_en[1];
            2'd2:       sel = src_en[2];
            default:    sel = src_en[0];
        endcase
    end

    assign eff       = (div == '0) ? DIV_W'(1) : div;
    assign base_tick = !rst && sel && (cnt == eff - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (sel) begin
            if (cnt == eff - DIV_W'(1)) cnt <= '0;
            else                        cnt <= cnt + DIV_W'(1);
        end
    end

    AST_PREDIV_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt < eff); // R2
    AST_IDLE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        !sel |-> !base_tick); // R1
endmodule

// File: rtl/cpr_phase.sv
module cpr_phase
    import cpr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic base_tick,
    input  logic mode6,
    output logic tick_full,
    output logic tick_half,
    output logic tick_mid,
    output logic tick_slow,
    output logic boundary
);
    phase_t state, nxt;

    always_comb begin
        nxt = state;
        if (base_tick) begin
            unique case (state)
                PH0:     nxt = PH1;
                PH1:     nxt = PH2;
                PH2:     nxt = PH3;
                PH3:     nxt = mode6 ? PH4 : PH0;
                PH4:     nxt = PH5;
                PH5:     nxt = PH0;
                default: nxt = PH0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PH0;
        else     state <= nxt;
    end

    always_comb begin
        tick_full = base_tick;
        tick_half = base_tick && (state == PH0 || state == PH2 || state == PH4);
        tick_mid  = base_tick && (mode6 ? (state == PH0 || state == PH3)
                                        : (state == PH0 || state == PH2));
        tick_slow = base_tick && (state == PH0);
        boundary  = base_tick && (mode6 ? (state == PH5) : (state == PH3));
    end

    AST_SLOW_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        tick_slow |-> (tick_full && tick_half && tick_mid)); // R7
    AST_SUB_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        (tick_half || tick_mid) |-> tick_full); // R7
    AST_HALF_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick_half |=> !tick_half); // R4
    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        !mode6 |-> (state == PH0 || state == PH1 || state == PH2 || state == PH3)); // R6
    AST_WRAP_TO_SLOW: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (state == PH0)); // R8
endmodule

// File: rtl/cpu_ratio_gen.sv
module cpu_ratio_gen
    import cpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] src_en,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output logic             tick_full,
    output logic             tick_half,
    output logic             tick_mid,
    output logic             tick_slow
);
    cfg_t act;
    logic base_tick;
    logic boundary;

    cpr_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .apply   (boundary),
        .act     (act)
    );

    cpr_prediv u_prediv (
        .clk       (clk),
        .rst       (rst),
        .src_en    (src_en),
        .src_code  (act.src_code),
        .div       (act.div),
        .base_tick (base_tick)
    );

    cpr_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .base_tick (base_tick),
        .mode6     (act.mode6),
        .tick_full (tick_full),
        .tick_half (tick_half),
        .tick_mid  (tick_mid),
        .tick_slow (tick_slow),
        .boundary  (boundary)
    );

    always_comb begin
        if (rst) begin
            AST_QUIET_RESET: assert (!tick_full && !tick_half && !tick_mid && !tick_slow); // R9
        end
    end
endmodule

// File: tb/sim_cpu_ratio_gen.sv
`timescale 1ns/1ps
module sim_cpu_ratio_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  src_en;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [13:0] wr_data = '0;
    logic        tick_full, tick_half, tick_mid, tick_slow;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign src_en = {(cyc % 3) == 0, (cyc % 2) == 0, 1'b1};

    cpu_ratio_gen u0 (
        .clk(clk), .rst(rst), .src_en(src_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick_full(tick_full), .tick_half(tick_half),
        .tick_mid(tick_mid), .tick_slow(tick_slow)
    );

    // {control word [15:0], ratio bit, expected base-pulse gap in cycles [7:0]}
    // gap = source period (code0/1:2, code2:3, code3:1) * effective divisor
    localparam logic [24:0] VEC [7] = '{
        {16'h0300, 1'b0, 8'd6},
        {16'h0210, 1'b1, 8'd4},
        {16'h0120, 1'b1, 8'd3},
        {16'h0530, 1'b0, 8'd5},
        {16'h0030, 1'b1, 8'd1},
        {16'h3F20, 1'b0, 8'd189},
        {16'h0430, 1'b1, 8'd4}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic addr, input logic [13:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_slow();
        for (int i = 0; i < 2000; i++) begin
            step();
            if (tick_slow) break;
        end
    endtask

    task automatic measure(output int len, output int nfull, output int nhalf,
                           output int nmid, output int gap, output int aligned);
        wait_slow();
        aligned = (tick_full && tick_half && tick_mid) ? 1 : 0;
        nfull = 1; nhalf = 1; nmid = 1; gap = 0; len = 1;
        for (int i = 0; i < 2000; i++) begin
            step();
            if (tick_slow) break;
            len++;
            if (tick_full) begin
                if (nfull == 1) gap = len - 1;
                nfull++;
            end
            if (tick_half) nhalf++;
            if (tick_mid)  nmid++;
        end
        if (nfull == 1) gap = len;
    endtask

    initial begin
        #1_000_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int len, nf, nh, nm, gp, al, quiet, seen;
        // R9: quiet during reset
        quiet = 1;
        for (int i = 0; i < 6; i++) begin
            step();
            if (tick_full || tick_half || tick_mid || tick_slow) quiet = 0;
        end
        check("R9 quiet in reset", quiet, 1);
        step(); rst = 1'b0;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (tick_full) begin seen = tick_slow ? 1 : 2; break; end
        end
        check("R9 first pulse is slow", seen, 1);
        measure(len, nf, nh, nm, gp, al);
        check("R9 default gap", gp, 2);
        check("R9 default slow period", len, 8);

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        foreach (VEC[v]) begin
            logic [15:0] ctl;
            logic        m6;
            int          eg;
            ctl = VEC[v][24:9]; m6 = VEC[v][8]; eg = int'(VEC[v][7:0]);
            wr(1'b0, ctl[13:0]);
            wr(1'b1, {13'd0, m6});
            wait_slow();
            measure(len, nf, nh, nm, gp, al);
            check("R1 R2 R3 gap", gp, eg);
            check(m6 ? "R5 slow period" : "R6 slow period", len, eg * (m6 ? 6 : 4));
            check(m6 ? "R5 full count" : "R6 full count", nf, m6 ? 6 : 4);
            check("R4 half count", nh, m6 ? 3 : 2);
            check(m6 ? "R5 mid count" : "R6 mid count", nm, 2);
            check("R7 aligned at slow", al, 1);
        end

        // R10: write with strobe low ignored (active: code3 div4 mode1, gap 4)
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 1'b0; wr_data = 14'h0130;
        step(); step();
        wait_slow();
        measure(len, nf, nh, nm, gp, al);
        check("R10 strobe low ignored", gp, 4);

        // R8: deferral (code3 div1 mode0, base every cycle)
        wr(1'b0, 14'h0130);
        wr(1'b1, 14'h0000);
        wait_slow();
        measure(len, nf, nh, nm, gp, al);
        check("R8 setup gap", gp, 1);
        wait_slow();
        wr(1'b0, 14'h0530);
        begin
            int hits [8];
            int slow6;
            slow6 = 0;
            for (int i = 0; i < 8; i++) begin
                hits[i] = tick_full ? 1 : 0;
                if (i == 6) slow6 = tick_slow ? 1 : 0;
                step();
            end
            check("R8 old rate before boundary", hits[0] + hits[1], 2);
            check("R8 gap after boundary", hits[2] + hits[3] + hits[4] + hits[5], 0);
            check("R8 new period opens with slow", hits[6] + slow6, 2);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule